// File: doc/BRIEF.md
# Four-Channel Match-Restart Interval Timer

This block holds four interval timers that share one base tick. Each channel counts up from zero. When it counts on a cycle where its count already equals its programmed compare value, it sets its own pending flag and starts over from zero. With a compare value of N, a channel therefore raises its flag once every N+1 counting steps. Channels 0 and 1 take 8-bit compare values. Channels 2 and 3 take 16-bit compare values, written as two bytes.

Software reaches the block through a byte-wide register port with eight addresses. A control register enables each channel and selects a test mode. In test mode the counters step on every clock instead of only on the base tick. A combined status register does two jobs on a write. Its upper nibble carries write-one start strobes and its lower nibble holds the pending flags, which are cleared by writing one. One interrupt line reports every pending flag whose channel is enabled.

Top module: `quad_match_timer`

## Requirements
- R1: After reset, all eight registers read 0x00 and `irq` is low.
- R2: The control register sits at address 0. Bit i (i = 0..3) enables channel i, and bit 4 selects test mode. Bits 7:5 read as 0.
- R3: A running channel steps its count only on a clock where `tick` is high, or on every clock when test mode is set. With no tick and test mode clear, it never reaches a match.
- R4: Writing 1 to bit 4+i of the status register (address 1) starts channel i from count zero, but only if channel i is enabled. A start written to a disabled channel is ignored, and the start bits always read as 0.
- R5: A started channel sets pending bit i (status bit i) on its (N+1)-th counting step, where N is its compare value. It then restarts from zero, so the next flag follows N+1 steps later.
- R6: Channel 0 compares against address 2 and channel 1 against address 3, each 8 bits wide. Channel 2 uses address 4 as its low byte and address 5 as its high byte. Channel 3 uses address 6 as its low byte and address 7 as its high byte.
- R7: A write to a high byte is held back. Both bytes of the 16-bit value take effect together when the low byte is written. Until then the high address still reads the old byte, and the channel still uses the old value.
- R8: Writing 1 to status bit i (i = 0..3) clears pending flag i, and writing 0 leaves it unchanged. A match in the same cycle as the clear keeps the flag set.
- R9: Clearing a channel's enable stops it and returns its count to zero. When it is enabled again, it stays idle until a new start.
- R10: `irq` is high exactly when some pending flag is set and its channel is enabled. A pending flag stays set while its channel is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Base tick; one counting step per high clock |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Combined interrupt |

## Verification
The match period is swept across every compare value from 0 to 20, plus the largest 8-bit value, on both narrow channels. Wide-channel values are chosen to straddle the byte boundary (255, 256, 511), which separates an off-by-one in the restart from a fault in the byte assembly. Tick-only counting is tried with and without tick pulses, so that counting on idle clocks can be told apart from counting on ticks. Further patterns cover a start on a disabled channel, a disable in the middle of a count, writing zeros to a set flag, and a high byte written alone. Each of these separates a missing gate from a correct one.

// File: rtl/qmt_pkg.sv
package qmt_pkg;
  localparam int NCH       = 4;
  localparam int NARROW_CH = 2;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_STAT  = 3'd1,
    A_CMP0  = 3'd2,
    A_CMP1  = 3'd3,
    A_CMP2L = 3'd4,
    A_CMP2H = 3'd5,
    A_CMP3L = 3'd6,
    A_CMP3H = 3'd7
  } reg_addr_e;

  // Pending update: new matches win over a write-one clear.
  function automatic logic [NCH-1:0] pend_next(input logic [NCH-1:0] cur,
                                               input logic [NCH-1:0] clr,
                                               input logic [NCH-1:0] hit);
    return (cur & ~clr) | hit;
  endfunction

  // Interrupt combine: only enabled channels reach the line.
  function automatic logic irq_of(input logic [NCH-1:0] pend,
                                  input logic [NCH-1:0] en);
    return |(pend & en);
  endfunction
endpackage

// File: rtl/qmt_channel.sv
module qmt_channel #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         start,
  input  logic         adv,
  input  logic [W-1:0] cmp,
  output logic         hit,
  output logic         running
);
  logic [W-1:0] cnt_q;

  assign hit = en && running && adv && !start && (cnt_q == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt_q   <= '0;
    end else if (!en) begin
      running <= 1'b0;
      cnt_q   <= '0;
    end else if (start) begin
      running <= 1'b1;
      cnt_q   <= '0;
    end else if (hit) begin
      cnt_q   <= '0;
    end else if (running && adv) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/qmt_regs.sv
module qmt_regs
  import qmt_pkg::*;
#(
  parameter int NARROW_W = 8,
  parameter int WIDE_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BYTE_W-1:0]   wdata,
  output logic [BYTE_W-1:0]   rdata,
  input  logic [NCH-1:0]      hit,
  output logic [NCH-1:0]      en,
  output logic                test,
  output logic [NCH-1:0]      start,
  output logic [NCH-1:0]      clr,
  output logic [NCH-1:0]      pend,
  output logic [NARROW_W-1:0] cmp_n [NARROW_CH],
  output logic [WIDE_W-1:0]   cmp_w [NCH-NARROW_CH]
);
  localparam int HI_W = WIDE_W - BYTE_W;

  logic [NCH:0]    ctrl_q;
  logic [HI_W-1:0] hi_stage [NCH-NARROW_CH];
  logic            wr_ctrl, wr_stat;

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_stat = wr_en && (addr == A_STAT);
  assign en      = ctrl_q[NCH-1:0];
  assign test    = ctrl_q[NCH];
  assign start   = wr_stat ? (wdata[2*NCH-1:NCH] & en) : '0;
  assign clr     = wr_stat ? wdata[NCH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pend   <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata[NCH:0];
      pend <= pend_next(pend, clr, hit);
    end
  end

  for (genvar j = 0; j < NARROW_CH; j++) begin : g_narrow
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmp_n[j] <= '0;
      else if (wr_en && addr == ADDR_W'(A_CMP0 + j)) cmp_n[j] <= wdata[NARROW_W-1:0];
    end
  end

  for (genvar j = 0; j < NCH-NARROW_CH; j++) begin : g_wide
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(A_CMP2L + 2*j);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_stage[j] <= '0;
        cmp_w[j]    <= '0;
      end else if (wr_en && addr == LO_A) begin
        cmp_w[j]    <= {hi_stage[j], wdata};
      end else if (wr_en && addr == LO_A + 1'b1) begin
        hi_stage[j] <= wdata[HI_W-1:0];
      end
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = BYTE_W'(ctrl_q);
      A_STAT:  rdata = BYTE_W'(pend);
      A_CMP0:  rdata = BYTE_W'(cmp_n[0]);
      A_CMP1:  rdata = BYTE_W'(cmp_n[1]);
      A_CMP2L: rdata = cmp_w[0][BYTE_W-1:0];
      A_CMP2H: rdata = BYTE_W'(cmp_w[0][WIDE_W-1:BYTE_W]);
      A_CMP3L: rdata = cmp_w[1][BYTE_W-1:0];
      default: rdata = BYTE_W'(cmp_w[1][WIDE_W-1:BYTE_W]);
    endcase
  end
endmodule

// File: rtl/quad_match_timer.sv
module quad_match_timer
  import qmt_pkg::*;
#(
  parameter int NARROW_W = 8,
  parameter int WIDE_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              irq
);
  logic [NCH-1:0]      en_w, start_w, clr_w, pend_w, hit_w, run_w;
  logic                test_w, adv_w;
  logic [NARROW_W-1:0] cmp_n [NARROW_CH];
  logic [WIDE_W-1:0]   cmp_w [NCH-NARROW_CH];

  qmt_regs #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .hit(hit_w), .en(en_w), .test(test_w), .start(start_w),
    .clr(clr_w), .pend(pend_w), .cmp_n(cmp_n), .cmp_w(cmp_w)
  );

  assign adv_w = tick || test_w;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    if (i < NARROW_CH) begin : g_n
      qmt_channel #(.W(NARROW_W)) u_ch (
        .clk(clk), .rst_n(rst_n), .en(en_w[i]), .start(start_w[i]),
        .adv(adv_w), .cmp(cmp_n[i]), .hit(hit_w[i]), .running(run_w[i])
      );
    end else begin : g_w
      qmt_channel #(.W(WIDE_W)) u_ch (
        .clk(clk), .rst_n(rst_n), .en(en_w[i]), .start(start_w[i]),
        .adv(adv_w), .cmp(cmp_w[i-NARROW_CH]), .hit(hit_w[i]), .running(run_w[i])
      );
    end
  end

  assign irq = irq_of(pend_w, en_w);
endmodule

// File: rtl/qmt_chk.sv
module qmt_chk
  import qmt_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           tick,
  input logic           test,
  input logic [NCH-1:0] en,
  input logic [NCH-1:0] hit,
  input logic [NCH-1:0] run,
  input logic [NCH-1:0] pend,
  input logic [NCH-1:0] start,
  input logic [NCH-1:0] clr
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    // R5
    hit_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> pend[i]);
    // R8
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend[i]) |-> $past(clr[i]));
    // R9
    disable_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en[i] |=> !run[i]);
    // R4
    start_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run[i]) |-> $past(start[i]));
    // R3
    hit_needs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |-> ((tick || test) && run[i]));
  end
endmodule

bind quad_match_timer qmt_chk u_qmt_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .test(test_w), .en(en_w),
  .hit(hit_w), .run(run_w), .pend(pend_w), .start(start_w), .clr(clr_w)
);

// File: tb/test_quad_match_timer.sv
module test_quad_match_timer;
  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  quad_match_timer i_quad_match_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    addr = 3'(a); wdata = 8'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    addr = 3'(a); #1; v = int'(rdata);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wait_pend(input int ch, input int limit, output int cyc);
    int v;
    cyc = 0;
    forever begin
      rd(1, v);
      if (v[ch]) break;
      if (cyc >= limit) begin cyc = -1; break; end
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic set_cmp(input int ch, input int val);
    case (ch)
      0: wr(2, val);
      1: wr(3, val);
      2: begin wr(5, val >> 8); wr(4, val & 8'hFF); end
      default: begin wr(7, val >> 8); wr(6, val & 8'hFF); end
    endcase
  endtask

  // Test mode: one step per clock; expected first flag after val+1 clocks.
  task automatic period(input string tag, input int ch, input int val);
    int c;
    wr(0, 8'h10);
    set_cmp(ch, val);
    wr(0, 8'h10 | (1 << ch));
    wr(1, (1 << (ch + 4)) | 8'h0F);
    wait_pend(ch, val + 40, c);
    chk($sformatf("%s ch%0d cmp=%0d period", tag, ch, val), c, val + 1);
  endtask

  task automatic pulse_tick();
    tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int v, c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(a, v);
      chk($sformatf("R1 reg %0d after reset", a), v, 0);
    end
    chk("R1 irq after reset", int'(irq), 0);

    // R2 control readback
    wr(0, 8'hFF); rd(0, v); chk("R2 ctrl readback", v, 8'h1F);
    wr(0, 8'h00);

    // R6 compare registers at their addresses
    wr(2, 8'hA5); wr(3, 8'h3C);
    rd(2, v); chk("R6 cmp0 readback", v, 8'hA5);
    rd(3, v); chk("R6 cmp1 readback", v, 8'h3C);

    // R5 / R6 sweeps over the narrow channels
    for (int n = 0; n <= 20; n++) period("R5", n % 2, n);
    period("R6", 0, 255);
    period("R6", 1, 255);
    // R5 / R6 wide channels across the byte boundary
    period("R6", 2, 0);
    period("R6", 2, 255);
    period("R6", 2, 256);
    period("R6", 3, 511);
    period("R6", 3, 1000);

    // R5 restart from zero: second flag follows cmp+1 steps later
    period("R5", 0, 3);
    wr(1, 8'h01);
    wait_pend(0, 40, c);
    chk("R5 restart second period", c, 3);

    // R4 start on disabled channels is ignored; start bits read 0
    wr(0, 8'h10); wr(1, 8'h0F);
    wr(1, 8'hF0); idle(30);
    rd(1, v); chk("R4 start while disabled", v, 0);
    wr(2, 0); wr(0, 8'h11); idle(10);
    rd(1, v); chk("R4 enabled but never started", v, 0);
    wr(1, 8'h10); rd(1, v);
    chk("R4 start bits read zero", v & 8'hF0, 0);

    // R3 tick-only counting
    wr(0, 8'h00); wr(2, 2); wr(0, 8'h01); wr(1, 8'h1F);
    idle(20); rd(1, v); chk("R3 no tick no progress", v & 1, 0);
    pulse_tick(); pulse_tick();
    rd(1, v); chk("R3 two ticks", v & 1, 0);
    pulse_tick();
    rd(1, v); chk("R3 third tick flags", v & 1, 1);

    // R9 disable mid-count stops the channel
    wr(0, 8'h10); wr(2, 10); wr(0, 8'h11); wr(1, 8'h1F);
    idle(5); wr(0, 8'h10); wr(0, 8'h11); idle(30);
    rd(1, v); chk("R9 idle after re-enable", v & 1, 0);
    wr(1, 8'h10);
    wait_pend(0, 60, c); chk("R9 fresh start full period", c, 11);

    // R8 / R10 sticky flag, masking and clear
    wr(0, 8'h10);
    rd(1, v); chk("R10 flag kept while disabled", v & 1, 1);
    chk("R10 irq masked", int'(irq), 0);
    wr(1, 8'h0E); rd(1, v); chk("R8 write zero keeps flag", v & 1, 1);
    wr(0, 8'h01); #1; chk("R10 irq when enabled", int'(irq), 1);
    wr(1, 8'h01); rd(1, v); chk("R8 write one clears", v & 1, 0);
    chk("R10 irq after clear", int'(irq), 0);

    // R7 high byte held until low byte write
    wr(0, 8'h10); wr(5, 0); wr(4, 5);
    wr(5, 8'h01);
    rd(5, v); chk("R7 high byte not committed", v, 0);
    wr(0, 8'h14); wr(1, 8'h4F);
    wait_pend(2, 60, c); chk("R7 old value in use", c, 6);
    wr(0, 8'h10); wr(4, 8'h00);
    rd(5, v); chk("R7 committed by low write", v, 1);
    wr(0, 8'h14); wr(1, 8'h4F);
    wait_pend(2, 400, c); chk("R7 new value in use", c, 257);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule